// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a three-wire serial memory link. It drives chip select, the serial clock and the data-in line of the memory, and it samples the memory's data-out line. A local command port carries an operation code, a word address, write data, a burst length and a one-cycle start strobe. The controller turns each command into a serial instruction, gathers read words, and waits for the memory to finish internal programming before it reports completion.

Word mode is set at build time. In 16-bit mode the memory has 64 words and 6 address bits. In 8-bit mode it has 128 bytes and 7 address bits. The serial clock runs at a fraction of the system clock set by a divider parameter. Two further parameters set the minimum chip-select low time and the ready-poll timeout.

The controller tracks whether the memory's programming enable is known to be set. If a modifying command arrives while that is not known, the controller first sends an enable instruction by itself.

Top module: `mw_host_ctrl`

## Requirements
- R1: Each instruction is shifted out MSB first as a 1 start bit, a 2-bit opcode and an address of 6 bits (16-bit mode) or 7 bits (8-bit mode). For write and write-all, the data word follows, MSB first.
- R2: `cmd_op` codes are 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 enable, 6 disable. Read, write and erase use opcodes 10, 01 and 11 with the user address. The other four use opcode 00 with address prefix 10 (erase-all), 01 (write-all), 11 (enable) or 00 (disable), and zeros below the prefix.
- R3: On a read, the dummy 0 that precedes the data is never taken as data. The following word bits are assembled MSB first into `rd_data`.
- R4: A read with `cmd_len` = N returns N consecutive words while chip select stays high, with no dummy bit between words. The address wraps from the last location to 0. A `cmd_len` of 0 reads one word.
- R5: Chip select stays low for at least CS_GAP system cycles before every instruction. After a write-type instruction, chip select goes low, rises again and the data-out line is sampled every cycle. `done` pulses once a 1 (ready) is seen.
- R6: A write, erase, erase-all or write-all request is preceded by an automatic enable instruction unless an enable has been sent since reset or since the last disable. While enable is known to be set, no extra enable is sent.
- R7: If ready is not seen within POLL_MAX cycles of polling, chip select drops and `err` pulses together with `done`.
- R8: A command is accepted only while `busy` is low. A strobe while busy, or with code 7, has no effect.
- R9: `rd_valid` is a one-cycle pulse per word returned. `done` is a one-cycle pulse per accepted command.
- R10: After reset, `mem_cs`, `mem_sk`, `busy`, `done` and `rd_valid` are low.
- R11: `mem_di` changes only while `mem_sk` is low. `mem_sk` is low whenever `mem_cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command start strobe |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_addr | input | AW | Word address |
| cmd_wdata | input | DW | Write data for write and write-all |
| cmd_len | input | LEN_W | Words to read in a burst |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (pulse) |
| err | output | 1 | Ready-poll timeout (pulse with done) |
| rd_valid | output | 1 | Read word valid (pulse) |
| rd_data | output | DW | Read word |
| mem_cs | output | 1 | Memory chip select |
| mem_sk | output | 1 | Memory serial clock |
| mem_di | output | 1 | Serial data to memory |
| mem_do | input | 1 | Serial data / ready from memory |

## Verification
The hardest cases to reach are a memory that never reports ready and a second command strobed while a write is still being polled. The bench's memory model has a switch that holds the busy indication. It also sends an extra strobe while busy is high and later reads back the untouched location. A burst read that starts two words before the top of the array exercises the address wrap. A disable followed by a write shows the automatic re-enable.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ERASE     = 3'd2,
    OP_ERASE_ALL = 3'd3,
    OP_WRITE_ALL = 3'd4,
    OP_WR_EN     = 3'd5,
    OP_WR_DIS    = 3'd6
  } mw_op_e;

  // operations that program the array and need a ready poll
  function automatic logic op_modifies(mw_op_e op);
    return op inside {OP_WRITE, OP_ERASE, OP_ERASE_ALL, OP_WRITE_ALL};
  endfunction

  function automatic logic op_has_data(mw_op_e op);
    return op inside {OP_WRITE, OP_WRITE_ALL};
  endfunction

endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
  parameter int DIV = 4,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= (cnt_q == CW'(DIV - 1));
      cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  generate
    if (DIV > 1) begin : g_tick_chk
      // R11: each SK phase lasts at least two system cycles
      p_tick_single_r11: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/mw_frame_build.sv
module mw_frame_build
  import mw_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  localparam int FW  = 3 + AW + DW,
  localparam int NBW = $clog2(FW + 1)
) (
  input  mw_op_e          op,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [FW-1:0]   frame,
  output logic [NBW-1:0]  nbits
);

  logic [1:0]    opc;
  logic [AW-1:0] fld;

  always_comb begin
    case (op)
      OP_READ:      begin opc = 2'b10; fld = addr; end
      OP_WRITE:     begin opc = 2'b01; fld = addr; end
      OP_ERASE:     begin opc = 2'b11; fld = addr; end
      OP_ERASE_ALL: begin opc = 2'b00; fld = {2'b10, {(AW-2){1'b0}}}; end
      OP_WRITE_ALL: begin opc = 2'b00; fld = {2'b01, {(AW-2){1'b0}}}; end
      OP_WR_EN:     begin opc = 2'b00; fld = {2'b11, {(AW-2){1'b0}}}; end
      default:      begin opc = 2'b00; fld = {2'b00, {(AW-2){1'b0}}}; end
    endcase
    // left aligned: bit FW-1 leaves first
    frame = {1'b1, opc, fld, op_has_data(op) ? wdata : {DW{1'b0}}};
    nbits = op_has_data(op) ? NBW'(FW) : NBW'(FW - DW);
  end

endmodule

// File: rtl/mw_host_ctrl.sv
module mw_host_ctrl
  import mw_pkg::*;
#(
  parameter bit WORD16   = 1'b1,
  parameter int CLK_DIV  = 4,
  parameter int CS_GAP   = 8,
  parameter int POLL_MAX = 100000,
  parameter int LEN_W    = 7,
  localparam int AW = WORD16 ? 6 : 7,
  localparam int DW = WORD16 ? 16 : 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [DW-1:0]    cmd_wdata,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             mem_cs,
  output logic             mem_sk,
  output logic             mem_di,
  input  logic             mem_do
);

  localparam int FW  = 3 + AW + DW;
  localparam int NBW = $clog2(FW + 1);
  localparam int DCW = $clog2(DW + 1);
  localparam int GW  = $clog2(CS_GAP + 1);
  localparam int PW  = $clog2(POLL_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_SEND, S_RECV, S_PGAP, S_POLL} st_e;

  st_e              state_q;
  mw_op_e           op_q, pend_q, cmd_e;
  logic             chain_q, en_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, rsh_q, rdata_q;
  logic [LEN_W-1:0] words_q;
  logic [FW-1:0]    sh_q, frame;
  logic [NBW-1:0]   bits_q, nbits;
  logic [DCW-1:0]   rbits_q;
  logic [GW-1:0]    gap_q;
  logic [PW-1:0]    poll_q;
  logic             cs_q, sk_q, di_q, done_q, err_q, rdv_q;
  logic             tick, fall;
  logic             fin_send, fin_recv, fin_ok, fin_to, fin;

  assign cmd_e = mw_op_e'(cmd_op);

  mw_tick #(.DIV(CLK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  mw_frame_build #(.AW(AW), .DW(DW)) u_frame (
    .op(op_q), .addr(addr_q), .wdata(wdata_q), .frame(frame), .nbits(nbits)
  );

  always_comb begin
    fall     = tick && sk_q;
    fin_send = (state_q == S_SEND) && fall && (bits_q == NBW'(1)) &&
               (op_q inside {OP_WR_EN, OP_WR_DIS});
    fin_recv = (state_q == S_RECV) && fall && (rbits_q == DCW'(1)) &&
               (words_q == LEN_W'(1));
    fin_ok   = (state_q == S_POLL) && mem_do;
    fin_to   = (state_q == S_POLL) && !mem_do && (poll_q == PW'(POLL_MAX - 1));
    fin      = fin_send || fin_recv || fin_ok || fin_to;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      op_q    <= OP_READ;
      pend_q  <= OP_READ;
      chain_q <= 1'b0;
      en_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      words_q <= '0;
      sh_q    <= '0;
      bits_q  <= '0;
      rbits_q <= '0;
      rsh_q   <= '0;
      rdata_q <= '0;
      gap_q   <= '0;
      poll_q  <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rdv_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (cmd_valid && cmd_op <= 3'd6) begin
          addr_q  <= cmd_addr;
          wdata_q <= cmd_wdata;
          words_q <= (cmd_len == '0) ? LEN_W'(1) : cmd_len;
          gap_q   <= '0;
          state_q <= S_GAP;
          if (op_modifies(cmd_e) && !en_q) begin
            op_q    <= OP_WR_EN;
            pend_q  <= cmd_e;
            chain_q <= 1'b1;
          end else begin
            op_q    <= cmd_e;
            chain_q <= 1'b0;
          end
        end
        S_GAP: if (gap_q == GW'(CS_GAP - 1)) begin
          cs_q    <= 1'b1;
          sk_q    <= 1'b0;
          sh_q    <= frame;
          di_q    <= frame[FW-1];
          bits_q  <= nbits;
          state_q <= S_SEND;
        end else begin
          gap_q <= gap_q + 1'b1;
        end
        S_SEND: if (tick) begin
          if (!sk_q) begin
            sk_q <= 1'b1;
          end else begin
            sk_q <= 1'b0;
            if (bits_q == NBW'(1)) begin
              di_q <= 1'b0;
              if (op_q == OP_READ) begin
                rbits_q <= DCW'(DW);
                state_q <= S_RECV;
              end else if (op_modifies(op_q)) begin
                cs_q    <= 1'b0;
                gap_q   <= '0;
                state_q <= S_PGAP;
              end
            end else begin
              sh_q   <= sh_q << 1;
              di_q   <= sh_q[FW-2];
              bits_q <= bits_q - 1'b1;
            end
          end
        end
        S_RECV: if (tick) begin
          if (!sk_q) begin
            sk_q <= 1'b1;
          end else begin
            sk_q  <= 1'b0;
            rsh_q <= {rsh_q[DW-2:0], mem_do};
            if (rbits_q == DCW'(1)) begin
              rdv_q   <= 1'b1;
              rdata_q <= {rsh_q[DW-2:0], mem_do};
              rbits_q <= DCW'(DW);
              words_q <= words_q - 1'b1;
            end else begin
              rbits_q <= rbits_q - 1'b1;
            end
          end
        end
        S_PGAP: if (gap_q == GW'(CS_GAP - 1)) begin
          cs_q    <= 1'b1;
          poll_q  <= '0;
          state_q <= S_POLL;
        end else begin
          gap_q <= gap_q + 1'b1;
        end
        S_POLL: poll_q <= poll_q + 1'b1;
        default: state_q <= S_IDLE;
      endcase
      if (fin) begin
        cs_q  <= 1'b0;
        sk_q  <= 1'b0;
        di_q  <= 1'b0;
        gap_q <= '0;
        if (fin_send) en_q <= (op_q == OP_WR_EN);
        chain_q <= 1'b0;
        if (chain_q && !fin_to) begin
          op_q    <= pend_q;
          state_q <= S_GAP;
        end else begin
          done_q  <= 1'b1;
          err_q   <= fin_to;
          state_q <= S_IDLE;
        end
      end
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdata_q;
  assign mem_cs   = cs_q;
  assign mem_sk   = sk_q;
  assign mem_di   = di_q;

  // chip-select low time observer for the assertions
  logic [GW-1:0] low_cnt_q;
  always_ff @(posedge clk) begin
    if (rst)                          low_cnt_q <= '0;
    else if (cs_q)                    low_cnt_q <= '0;
    else if (low_cnt_q != GW'(CS_GAP)) low_cnt_q <= low_cnt_q + 1'b1;
  end

  p_cs_gap_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_cs) |-> $past(low_cnt_q) >= GW'(CS_GAP - 1));
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  p_idle_cs_low_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_cs);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_rdv_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  p_sk_low_cs_low_r11: assert property (@(posedge clk) disable iff (rst)
    !mem_cs |-> !mem_sk);
  p_di_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_sk && $past(mem_sk)) |-> $stable(mem_di));

endmodule

// File: tb/mw_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module mw_host_ctrl_tb_top;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NW = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [3:0]    cmd_len = '0;
  logic          busy, done, err, rd_valid, mem_cs, mem_sk, mem_di, mem_do;
  logic [DW-1:0] rd_data;

  mw_host_ctrl #(.WORD16(1'b1), .CLK_DIV(2), .CS_GAP(4), .POLL_MAX(300), .LEN_W(4)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_len(cmd_len), .busy(busy), .done(done), .err(err),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_cs(mem_cs), .mem_sk(mem_sk),
    .mem_di(mem_di), .mem_do(mem_do)
  );

  // ---------------- behavioural serial memory ----------------
  logic [DW-1:0] dmem [NW];
  logic [31:0]   dsh = '0;
  int            hdr_bits = 0, rd_pos = 0, busy_cnt = 0, ewen_cnt = 0, pend_kind = 0;
  logic          rd_act = 1'b0, rd_bit = 1'b0, wen_dev = 1'b0, stuck = 1'b0;
  logic          prev_sk = 1'b0, prev_cs = 1'b0;
  logic [AW-1:0] rd_addr = '0, pend_addr = '0;
  logic [DW-1:0] pend_data = '0;
  logic [8:0]    last_hdr = '0;

  assign mem_do = rd_act ? rd_bit : !(stuck || busy_cnt != 0);

  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt--;
    if (prev_cs && !mem_cs) begin
      if (pend_kind != 0 && wen_dev) begin
        case (pend_kind)
          1: dmem[pend_addr] = pend_data;
          2: dmem[pend_addr] = '1;
          3: for (int i = 0; i < NW; i++) dmem[i] = '1;
          default: for (int i = 0; i < NW; i++) dmem[i] = pend_data;
        endcase
        busy_cnt = 40;
      end
      pend_kind = 0;
      hdr_bits  = 0;
      rd_act    = 1'b0;
    end else if (mem_cs && mem_sk && !prev_sk) begin
      if (rd_act) begin
        rd_bit = dmem[rd_addr][rd_pos];
        if (rd_pos == 0) begin rd_pos = DW - 1; rd_addr = rd_addr + 1'b1; end
        else rd_pos--;
      end else if (hdr_bits != 0 || mem_di) begin
        dsh = {dsh[30:0], mem_di};
        hdr_bits++;
        if (hdr_bits == 3 + AW) begin
          last_hdr = dsh[8:0];
          case (dsh[7:6])
            2'b10: begin rd_act = 1'b1; rd_bit = 1'b0; rd_pos = DW - 1; rd_addr = dsh[5:0]; end
            2'b11: begin pend_kind = 2; pend_addr = dsh[5:0]; end
            2'b00: case (dsh[5:4])
              2'b11: begin wen_dev = 1'b1; ewen_cnt++; end
              2'b00: wen_dev = 1'b0;
              2'b10: pend_kind = 3;
              default: ;
            endcase
            default: ;
          endcase
        end
        if (hdr_bits == 3 + AW + DW) begin
          if (dsh[23:22] == 2'b01) begin
            pend_kind = 1; pend_addr = dsh[21:16]; pend_data = dsh[15:0];
          end else if (dsh[23:20] == 4'b0001) begin
            pend_kind = 4; pend_data = dsh[15:0];
          end
        end
      end
    end
    prev_sk = mem_sk;
    prev_cs = mem_cs;
  end

  // ---------------- reference and per-cycle monitor ----------------
  logic [DW-1:0] ref_mem [NW];
  logic [DW-1:0] exp_q [$];
  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
  int done_cnt = 0, err_cnt = 0, rd_seen = 0, cyc = 0;
  logic last_sk = 1'b0, last_di = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        logic [DW-1:0] e;
        rd_seen++;
        mon_chk++;
        e = (exp_q.size() != 0) ? exp_q.pop_front() : 16'hxxxx;
        if (rd_data !== e) begin
          mon_fail++;
          $display("FAIL R3/R4 read word actual=%h expected=%h", rd_data, e);
        end
      end
      if (done) done_cnt++;
      if (err) err_cnt++;
      if (mem_sk && last_sk && mem_di !== last_di) begin
        mon_chk++; mon_fail++;
        $display("FAIL R11 di moved while sk high actual=%b expected=%b", mem_di, last_di);
      end
    end
    last_sk = mem_sk;
    last_di = mem_di;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk + mon_chk + 1, n_fail + mon_fail + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input int op, input int a, input logic [DW-1:0] d, input int len);
    int dn;
    while (busy) @(negedge clk);
    case (op)
      0: for (int i = 0; i < ((len == 0) ? 1 : len); i++) exp_q.push_back(ref_mem[(a + i) % NW]);
      1: ref_mem[a] = d;
      2: ref_mem[a] = '1;
      3: for (int i = 0; i < NW; i++) ref_mem[i] = '1;
      4: for (int i = 0; i < NW; i++) ref_mem[i] = d;
      default: ;
    endcase
    cmd_op = 3'(op); cmd_addr = 6'(a); cmd_wdata = d; cmd_len = 4'(len);
    dn = done_cnt;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (done_cnt == dn) @(negedge clk);
  endtask

  initial begin
    int dn, rs;
    repeat (5) @(negedge clk);
    chk(mem_cs == 1'b0, "R10 cs", 32'(mem_cs), 0);
    chk(mem_sk == 1'b0, "R10 sk", 32'(mem_sk), 0);
    chk(busy == 1'b0, "R10 busy", 32'(busy), 0);
    chk(done == 1'b0 && rd_valid == 1'b0, "R10 pulses", 32'(done), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    do_cmd(4, 0, 16'h0F0F, 0);
    chk(ewen_cnt == 1, "R6 auto enable", 32'(ewen_cnt), 1);
    chk(last_hdr == 9'b1_00_010000, "R2 write-all header", 32'(last_hdr), 9'b100010000);
    do_cmd(1, 63, 16'hBEEF, 0);
    chk(busy_cnt == 0 && err_cnt == 0, "R5 done after ready", 32'(busy_cnt), 0);
    do_cmd(1, 0, 16'h0001, 0);
    do_cmd(1, 5, 16'hA5C3, 0);
    chk(ewen_cnt == 1, "R6 no repeat enable", 32'(ewen_cnt), 1);

    do_cmd(0, 5, '0, 1);
    chk(last_hdr == 9'b1_10_000101, "R1 read header", 32'(last_hdr), 9'b110000101);
    rs = rd_seen;
    do_cmd(0, 62, '0, 4);
    chk(rd_seen - rs == 4, "R4 burst word count", 32'(rd_seen - rs), 4);
    rs = rd_seen;
    do_cmd(0, 1, '0, 0);
    chk(rd_seen - rs == 1, "R4 zero length reads one", 32'(rd_seen - rs), 1);

    do_cmd(2, 5, '0, 0);
    chk(last_hdr == 9'b1_11_000101, "R2 erase header", 32'(last_hdr), 9'b111000101);
    do_cmd(0, 5, '0, 1);

    do_cmd(6, 0, '0, 0);
    chk(last_hdr == 9'b1_00_000000, "R2 disable header", 32'(last_hdr), 0);
    do_cmd(1, 7, 16'h7777, 0);
    chk(ewen_cnt == 2, "R6 re-enable after disable", 32'(ewen_cnt), 2);
    do_cmd(0, 7, '0, 1);

    do_cmd(3, 0, '0, 0);
    do_cmd(0, 3, '0, 2);

    // R8: strobe while busy and an invalid code are ignored
    dn = done_cnt;
    cmd_op = 3'd1; cmd_addr = 6'd9; cmd_wdata = 16'h1111; cmd_len = '0;
    cmd_valid = 1'b1; @(negedge clk); cmd_valid = 1'b0;
    ref_mem[9] = 16'h1111;
    repeat (10) @(negedge clk);
    cmd_op = 3'd1; cmd_addr = 6'd10; cmd_wdata = 16'h5555;
    cmd_valid = 1'b1; @(negedge clk); cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    cmd_op = 3'd7; cmd_valid = 1'b1; @(negedge clk); cmd_valid = 1'b0;
    repeat (300) @(negedge clk);
    chk(done_cnt - dn == 1, "R8 single completion", 32'(done_cnt - dn), 1);
    chk(busy == 1'b0, "R8 code 7 ignored", 32'(busy), 0);
    do_cmd(0, 9, '0, 2);

    // R7: memory never reports ready
    stuck = 1'b1;
    do_cmd(1, 20, 16'h2020, 0);
    chk(err_cnt == 1, "R7 timeout error", 32'(err_cnt), 1);
    chk(mem_cs == 1'b0, "R7 cs released", 32'(mem_cs), 0);
    stuck = 1'b0;

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all words returned", 32'(exp_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end

endmodule